// File: doc/BRIEF.md
# Device feature list walker

The walker is a hardware engine that discovers the features placed in a memory-mapped region. Each feature is announced by a chain of 64-bit header words. After a one-cycle start pulse, the walker fetches the header at a configured base address over a simple 64-bit read port, with a single request in flight at a time. It decodes the header's format version and, for the extended format, fetches four more words. These are the two halves of a 128-bit identifier, a word that locates the feature's registers, and a word that describes the register set. The walker then follows the next-header offsets until a header marks the end of the list.

For every feature, the walker emits one descriptor record. The record carries the type, format version, revision, ID, identifier, the resolved register address, the register-set size, the group and the instance. When an extended header says that parameters are present, the walker follows a second chain of parameter headers inside that feature. It emits each parameter's ID, version and address on a separate output, after the feature's own record.

Both outputs use a valid/ready handshake, and back-pressure stalls the walk. A header with an unknown format version is reported and ends the walk. Runaway lists are cut off by counting limits, and hitting a limit raises a sticky error.

Top module: `dfl_walker`

## Requirements
- R1: After reset, busy_o, done_o, rd_req_o, feat_valid_o, prm_valid_o and err_lim_o are all 0.
- R2: A start_i pulse while idle causes the first read at base_addr_i. busy_o stays 1 until the walk ends, and done_o is then 1 for exactly one cycle with busy_o at 0.
- R3: Header word fields are decoded as follows, and the type, version, revision and ID appear on the record:
  - type: bits 63:60
  - format version: bits 59:52
  - end flag: bit 40
  - next-header offset: bits 39:16
  - revision: bits 15:12
  - ID: bits 11:0
- R4: A format-0 header gives register address = header + 8, with the identifier, size, group and instance all reported as 0. If the end flag is 0, the next header is read at header + offset. The walk ends after a header whose end flag is 1.
- R5: A format-1 header is followed by reads at header+8 (identifier low half), +16 (high half), +24 (location word) and +32 (set word), in that order. The record's identifier is {high, low}. From the set word, the size is bits 63:32, the params-present flag is bit 31, the group is bits 30:16 and the instance is bits 15:0.
- R6: In the location word, the value with bit 0 cleared is an offset added to the header address when bit 0 is 1, and an absolute address when bit 0 is 0.
- R7: When the params-present flag is set, the first parameter header is read at header+40, after the feature record has been accepted. Each parameter header reports its ID (bits 15:0), version (bits 31:16) and its own address. The next parameter is at the current address + bits 63:32. The chain stops when that offset is 0.
- R8: A header whose format version is neither 0 nor 1 is emitted with feat_bad_o = 1, and the walk then ends with no further reads.
- R9: If MAX_FEAT features have been emitted and the last one does not end the list, err_lim_o is set, the walk ends with no further reads, and err_lim_o stays 1 until the next start_i.
- R10: If MAX_PRM parameters of one feature have been emitted and the last offset is nonzero, err_lim_o is set and the walk ends with no further reads.
- R11: While a record's valid is 1 and its ready is 0, the valid and all fields of that record hold.
- R12: At most one read is outstanding. No new rd_req_o is issued before rd_rvalid_i answers the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle start pulse |
| base_addr_i | input | AW | Address of the first header |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle end-of-walk pulse |
| err_lim_o | output | 1 | Sticky count-limit error |
| rd_req_o | output | 1 | Read request, one cycle |
| rd_addr_o | output | AW | Read byte address |
| rd_rvalid_i | input | 1 | Read data valid |
| rd_rdata_i | input | 64 | Read data |
| feat_valid_o | output | 1 | Feature record valid |
| feat_ready_i | input | 1 | Feature record accepted |
| feat_type_o | output | 4 | Feature type |
| feat_ver_o | output | 8 | Header format version |
| feat_rev_o | output | 4 | Feature revision |
| feat_id_o | output | 12 | Feature ID |
| feat_bad_o | output | 1 | Unknown format version |
| feat_guid_o | output | 128 | Feature identifier {high, low} |
| feat_regs_o | output | AW | Resolved register address |
| feat_size_o | output | 32 | Register-set size |
| feat_group_o | output | 15 | Group |
| feat_inst_o | output | 16 | Instance |
| prm_valid_o | output | 1 | Parameter record valid |
| prm_ready_i | input | 1 | Parameter record accepted |
| prm_id_o | output | 16 | Parameter ID |
| prm_ver_o | output | 16 | Parameter version |
| prm_addr_o | output | AW | Parameter header address |

## Verification
A plain chain of format-0 headers with differing offsets checks the decoding and the link arithmetic on their own. A mixed list checks the offset and absolute location modes and the parameter chain. That list combines format-1 headers in both location modes, a two-entry parameter chain and a closing format-0 header, and it runs under ready stalls and varying read latency, so ordering and hold behaviour are exercised together. Further patterns each target one termination path:
- an unknown version mid-list;
- a header that links to itself, against the feature limit;
- an over-long parameter chain;
- a clean walk after a limit error, which shows that the error is cleared on restart.

// File: rtl/dfl_walk_pkg.sv
package dfl_walk_pkg;
  typedef struct packed {
    logic [3:0]  ftype;
    logic [7:0]  ver;
    logic        eol;
    logic [23:0] next;
    logic [3:0]  rev;
    logic [11:0] id;
  } hdr_t;

  typedef enum logic [3:0] {
    S_IDLE, S_REQ, S_WAIT, S_DEC, S_FOUT, S_NEXT, S_POUT, S_PNXT, S_FIN
  } st_t;

  // value times 8 is the byte offset from the header, except W_PRM
  typedef enum logic [2:0] {
    W_HDR = 3'd0, W_GLO = 3'd1, W_GHI = 3'd2, W_LOC = 3'd3, W_SZ = 3'd4, W_PRM = 3'd5
  } wsel_t;
endpackage

// File: rtl/dfl_lim_cnt.sv
module dfl_lim_cnt #(
  parameter int MAX = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic hit_o
);
  localparam int W = $clog2(MAX + 1);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (inc_i && !hit_o)   cnt_q <= cnt_q + W'(1);
  end

  assign hit_o = (cnt_q == W'(MAX));
endmodule

// File: rtl/dfl_rd_addr.sv
module dfl_rd_addr import dfl_walk_pkg::*; #(
  parameter int AW = 32
) (
  input  wsel_t          sel_i,
  input  logic [AW-1:0]  hdr_addr_i,
  input  logic [AW-1:0]  prm_addr_i,
  output logic [AW-1:0]  addr_o
);
  always_comb begin
    if (sel_i == W_PRM) addr_o = prm_addr_i;
    else                addr_o = hdr_addr_i + AW'({sel_i, 3'b000});
  end
endmodule

// File: rtl/dfl_loc_resolve.sv
module dfl_loc_resolve #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] hdr_addr_i,
  input  logic [7:0]    ver_i,
  input  logic [AW-1:0] loc_i,
  output logic [AW-1:0] regs_o
);
  logic [AW-1:0] loc_even;
  assign loc_even = {loc_i[AW-1:1], 1'b0};

  always_comb begin
    unique case (ver_i)
      8'd0:    regs_o = hdr_addr_i + AW'(8);
      8'd1:    regs_o = loc_i[0] ? hdr_addr_i + loc_even : loc_even;
      default: regs_o = '0;
    endcase
  end
endmodule

// File: rtl/dfl_walker.sv
module dfl_walker import dfl_walk_pkg::*; #(
  parameter int AW       = 32,
  parameter int MAX_FEAT = 256,
  parameter int MAX_PRM  = 64
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [AW-1:0]  base_addr_i,
  output logic           busy_o,
  output logic           done_o,
  output logic           err_lim_o,
  output logic           rd_req_o,
  output logic [AW-1:0]  rd_addr_o,
  input  logic           rd_rvalid_i,
  input  logic [63:0]    rd_rdata_i,
  output logic           feat_valid_o,
  input  logic           feat_ready_i,
  output logic [3:0]     feat_type_o,
  output logic [7:0]     feat_ver_o,
  output logic [3:0]     feat_rev_o,
  output logic [11:0]    feat_id_o,
  output logic           feat_bad_o,
  output logic [127:0]   feat_guid_o,
  output logic [AW-1:0]  feat_regs_o,
  output logic [31:0]    feat_size_o,
  output logic [14:0]    feat_group_o,
  output logic [15:0]    feat_inst_o,
  output logic           prm_valid_o,
  input  logic           prm_ready_i,
  output logic [15:0]    prm_id_o,
  output logic [15:0]    prm_ver_o,
  output logic [AW-1:0]  prm_addr_o
);
  st_t           st_q;
  wsel_t         sel_q;
  hdr_t          hdr_q;
  logic [AW-1:0] cur_q, pa_q, loc_q;
  logic [63:0]   glo_q, ghi_q, sz_q, prm_q;
  logic          lim_q;
  logic          feat_acc, prm_acc, f_hit, p_hit, bad_ver;

  assign feat_acc = (st_q == S_FOUT) && feat_ready_i;
  assign prm_acc  = (st_q == S_POUT) && prm_ready_i;
  assign bad_ver  = (hdr_q.ver > 8'd1);

  dfl_lim_cnt #(.MAX(MAX_FEAT)) u_fcnt (
    .clk_i, .rst_ni,
    .clr_i ((st_q == S_IDLE) && start_i),
    .inc_i (feat_acc),
    .hit_o (f_hit)
  );

  dfl_lim_cnt #(.MAX(MAX_PRM)) u_pcnt (
    .clk_i, .rst_ni,
    .clr_i (feat_acc),
    .inc_i (prm_acc),
    .hit_o (p_hit)
  );

  dfl_rd_addr #(.AW(AW)) u_addr (
    .sel_i      (sel_q),
    .hdr_addr_i (cur_q),
    .prm_addr_i (pa_q),
    .addr_o     (rd_addr_o)
  );

  dfl_loc_resolve #(.AW(AW)) u_loc (
    .hdr_addr_i (cur_q),
    .ver_i      (hdr_q.ver),
    .loc_i      (loc_q),
    .regs_o     (feat_regs_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= S_IDLE;
      sel_q <= W_HDR;
      hdr_q <= '0;
      cur_q <= '0;
      pa_q  <= '0;
      loc_q <= '0;
      glo_q <= '0;
      ghi_q <= '0;
      sz_q  <= '0;
      prm_q <= '0;
      lim_q <= 1'b0;
    end else begin
      unique case (st_q)
        S_IDLE: if (start_i) begin
          cur_q <= base_addr_i;
          sel_q <= W_HDR;
          lim_q <= 1'b0;
          st_q  <= S_REQ;
        end
        S_REQ: st_q <= S_WAIT;
        S_WAIT: if (rd_rvalid_i) begin
          unique case (sel_q)
            W_HDR: begin
              hdr_q <= hdr_t'({rd_rdata_i[63:52], rd_rdata_i[40:0]});
              glo_q <= '0;
              ghi_q <= '0;
              loc_q <= '0;
              sz_q  <= '0;
              st_q  <= S_DEC;
            end
            W_GLO: begin glo_q <= rd_rdata_i; sel_q <= W_GHI; st_q <= S_REQ; end
            W_GHI: begin ghi_q <= rd_rdata_i; sel_q <= W_LOC; st_q <= S_REQ; end
            W_LOC: begin loc_q <= rd_rdata_i[AW-1:0]; sel_q <= W_SZ; st_q <= S_REQ; end
            W_SZ:  begin sz_q <= rd_rdata_i; st_q <= S_FOUT; end
            default: begin prm_q <= rd_rdata_i; st_q <= S_POUT; end
          endcase
        end
        S_DEC: begin
          if (hdr_q.ver == 8'd1) begin
            sel_q <= W_GLO;
            st_q  <= S_REQ;
          end else begin
            st_q  <= S_FOUT;
          end
        end
        S_FOUT: if (feat_ready_i) begin
          if (bad_ver) st_q <= S_FIN;
          else if (hdr_q.ver == 8'd1 && sz_q[31]) begin
            pa_q  <= cur_q + AW'(40);
            sel_q <= W_PRM;
            st_q  <= S_REQ;
          end else st_q <= S_NEXT;
        end
        S_NEXT: begin
          if (hdr_q.eol) st_q <= S_FIN;
          else if (f_hit) begin
            lim_q <= 1'b1;
            st_q  <= S_FIN;
          end else begin
            cur_q <= cur_q + AW'(hdr_q.next);
            sel_q <= W_HDR;
            st_q  <= S_REQ;
          end
        end
        S_POUT: if (prm_ready_i) st_q <= S_PNXT;
        S_PNXT: begin
          if (prm_q[63:32] == 32'd0) st_q <= S_NEXT;
          else if (p_hit) begin
            lim_q <= 1'b1;
            st_q  <= S_FIN;
          end else begin
            pa_q <= pa_q + AW'(prm_q[63:32]);
            st_q <= S_REQ;
          end
        end
        S_FIN:   st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o       = (st_q != S_IDLE) && (st_q != S_FIN);
  assign done_o       = (st_q == S_FIN);
  assign err_lim_o    = lim_q;
  assign rd_req_o     = (st_q == S_REQ);
  assign feat_valid_o = (st_q == S_FOUT);
  assign feat_type_o  = hdr_q.ftype;
  assign feat_ver_o   = hdr_q.ver;
  assign feat_rev_o   = hdr_q.rev;
  assign feat_id_o    = hdr_q.id;
  assign feat_bad_o   = bad_ver;
  assign feat_guid_o  = {ghi_q, glo_q};
  assign feat_size_o  = sz_q[63:32];
  assign feat_group_o = sz_q[30:16];
  assign feat_inst_o  = sz_q[15:0];
  assign prm_valid_o  = (st_q == S_POUT);
  assign prm_id_o     = prm_q[15:0];
  assign prm_ver_o    = prm_q[31:16];
  assign prm_addr_o   = pa_q;

  // R12: a request is never repeated back to back, and only one channel is active at a time
  p_one_rd_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |=> !rd_req_o);
  p_excl_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rd_req_o, feat_valid_o, prm_valid_o}));
  p_feat_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    feat_valid_o && !feat_ready_i |=> feat_valid_o && $stable(feat_id_o)
      && $stable(feat_regs_o) && $stable(feat_guid_o) && $stable(feat_size_o));
  p_prm_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prm_valid_o && !prm_ready_i |=> prm_valid_o && $stable(prm_addr_o) && $stable(prm_id_o));
  p_done_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_done_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  p_bad_end_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    feat_valid_o && feat_ready_i && feat_bad_o |=> done_o);
  p_lim_end_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_lim_o) |-> done_o);
endmodule

// File: tb/tb_dfl_walker.sv
module tb_dfl_walker;
  localparam int MF = 8;
  localparam int MP = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rst_n, start, rvalid, frdy, prdy;
  logic [31:0]  base;
  logic [63:0]  rdata;
  logic         busy, done, lim, rd_req, fv, fbad, pv;
  logic [31:0]  rd_addr, fregs, fsize, paddr;
  logic [3:0]   ftype, frev;
  logic [7:0]   fver;
  logic [11:0]  fid;
  logic [127:0] fguid;
  logic [14:0]  fgrp;
  logic [15:0]  finst, pid, pver;

  dfl_walker #(.AW(32), .MAX_FEAT(MF), .MAX_PRM(MP)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .base_addr_i(base),
    .busy_o(busy), .done_o(done), .err_lim_o(lim),
    .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_rvalid_i(rvalid), .rd_rdata_i(rdata),
    .feat_valid_o(fv), .feat_ready_i(frdy), .feat_type_o(ftype), .feat_ver_o(fver),
    .feat_rev_o(frev), .feat_id_o(fid), .feat_bad_o(fbad), .feat_guid_o(fguid),
    .feat_regs_o(fregs), .feat_size_o(fsize), .feat_group_o(fgrp), .feat_inst_o(finst),
    .prm_valid_o(pv), .prm_ready_i(prdy), .prm_id_o(pid), .prm_ver_o(pver), .prm_addr_o(paddr)
  );

  int total = 0;
  int bad = 0;
  logic [63:0]  mem [logic [31:0]];
  logic [31:0]  exp_rd [$];
  logic [255:0] exp_ev [$];
  logic         exp_lim;
  int           cyc = 0, nrd = 0, wait_cnt = 0, rdy_mode = 0;
  logic [31:0]  pend;
  logic         p_fv = 0, p_frdy = 0, p_pv = 0, p_prdy = 0;
  logic [255:0] p_fvec, p_pvec;
  logic [255:0] fvec, pvec;

  assign fvec = {4'b0, ftype, fver, frev, fid, fbad, fguid, fregs, fsize, fgrp, finst};
  assign pvec = {1'b1, 191'b0, pid, pver, paddr};

  task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] rdm(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 64'd0;
  endfunction

  function automatic logic [63:0] mk_hdr(input logic [3:0] t, input logic [7:0] v, input logic e,
                                         input logic [23:0] n, input logic [3:0] r, input logic [11:0] i);
    return {t, v, 11'b0, e, n, r, i};
  endfunction

  // behavioural walk of the memory image, from the requirements
  task automatic model(input logic [31:0] b);
    logic [31:0] a, regs, lo, pa;
    logic [63:0] h, w, loc, p, glo, ghi;
    logic [7:0]  v;
    logic        isbad;
    int          nf, np;
    a = b; nf = 0; exp_lim = 0;
    exp_rd.delete(); exp_ev.delete();
    forever begin
      h = rdm(a); exp_rd.push_back(a); v = h[59:52];
      glo = 0; ghi = 0; regs = 0; w = 0;
      isbad = (v > 8'd1);
      if (v == 8'd0) regs = a + 32'd8;
      else if (v == 8'd1) begin
        exp_rd.push_back(a + 32'd8);  exp_rd.push_back(a + 32'd16);
        exp_rd.push_back(a + 32'd24); exp_rd.push_back(a + 32'd32);
        glo = rdm(a + 32'd8); ghi = rdm(a + 32'd16); loc = rdm(a + 32'd24);
        lo = {loc[31:1], 1'b0};
        regs = loc[0] ? a + lo : lo;
        w = rdm(a + 32'd32);
      end
      exp_ev.push_back({4'b0, h[63:60], v, h[15:12], h[11:0], isbad, ghi, glo, regs,
                        w[63:32], w[30:16], w[15:0]});
      if (isbad) return;
      if (v == 8'd1 && w[31]) begin
        pa = a + 32'd40; np = 0;
        forever begin
          exp_rd.push_back(pa); p = rdm(pa);
          exp_ev.push_back({1'b1, 191'b0, p[15:0], p[31:16], pa});
          np++;
          if (p[63:32] == 32'd0) break;
          if (np == MP) begin exp_lim = 1; return; end
          pa = pa + p[63:32];
        end
      end
      nf++;
      if (h[40]) return;
      if (nf == MF) begin exp_lim = 1; return; end
      a = a + {8'b0, h[39:16]};
    end
  endtask

  // memory responder, ready drivers and record monitor, all away from the active edge
  always @(negedge clk) begin
    logic [255:0] e;
    cyc++;
    rvalid = 1'b0;
    if (wait_cnt > 0) begin
      if (rd_req) chk(0, "R12 request while one outstanding", 256'(rd_addr), 256'(pend));
      wait_cnt--;
      if (wait_cnt == 0) begin rvalid = 1'b1; rdata = rdm(pend); end
    end else if (rd_req) begin
      pend = rd_addr; wait_cnt = 1 + (nrd % 3); nrd++;
      if (exp_rd.size() == 0) chk(0, "R2 R4 R5 R7 unexpected read", 256'(pend), 256'(0));
      else begin
        e = 256'(exp_rd.pop_front());
        chk(256'(pend) == e, "R2 R4 R5 R6 R7 read address", 256'(pend), e);
      end
    end
    frdy = (rdy_mode == 0) ? 1'b1 : ((cyc % 4) >= 2);
    prdy = (rdy_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
    if (p_fv && !p_frdy) chk(fv && fvec == p_fvec, "R11 feature record held", fvec, p_fvec);
    if (p_pv && !p_prdy) chk(pv && pvec == p_pvec, "R11 parameter record held", pvec, p_pvec);
    if (fv && frdy) begin
      if (exp_ev.size() == 0) chk(0, "R3 R4 R5 R6 unexpected feature", fvec, 256'(0));
      else begin
        e = exp_ev.pop_front();
        chk(fvec == e, "R3 R4 R5 R6 R8 feature record", fvec, e);
      end
    end
    if (pv && prdy) begin
      if (exp_ev.size() == 0) chk(0, "R7 unexpected parameter", pvec, 256'(0));
      else begin
        e = exp_ev.pop_front();
        chk(pvec == e, "R7 parameter record and order", pvec, e);
      end
    end
    p_fv = fv; p_frdy = frdy; p_fvec = fvec;
    p_pv = pv; p_prdy = prdy; p_pvec = pvec;
  end

  task automatic run_walk(input logic [31:0] b, input int mode, input string tag);
    int n;
    model(b);
    rdy_mode = mode;
    @(negedge clk); base = b; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", 256'(busy), 256'(1));
    n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    chk(n < 5000, {tag, " walk finished"}, 256'(n), 256'(0));
    chk(lim == exp_lim, {tag, " limit flag at end"}, 256'(lim), 256'(exp_lim));
    chk(exp_rd.size() == 0 && exp_ev.size() == 0, {tag, " all reads and records seen"},
        256'(exp_rd.size() + exp_ev.size()), 256'(0));
    @(negedge clk);
    chk(!done && !busy, "R2 done lasts one cycle and idle follows", 256'({done, busy}), 256'(0));
    repeat (4) @(negedge clk);
  endtask

  initial begin
    logic [31:0] a;
    rst_n = 1'b0; start = 1'b0; base = '0; rvalid = 1'b0; rdata = '0; frdy = 1'b1; prdy = 1'b1;
    // T1: format-0 chain
    mem[32'h1000] = mk_hdr(4'h3, 8'd0, 1'b0, 24'h100, 4'h1, 12'h011);
    mem[32'h1100] = mk_hdr(4'h5, 8'd0, 1'b0, 24'h080, 4'h2, 12'h022);
    mem[32'h1180] = mk_hdr(4'h1, 8'd0, 1'b1, 24'h000, 4'h0, 12'h033);
    // T2: format-1 offset mode, format-1 absolute mode with two parameters, format-0 end
    mem[32'h2000] = mk_hdr(4'h4, 8'd1, 1'b0, 24'h200, 4'h3, 12'h101);
    mem[32'h2008] = 64'h1111_2222_3333_4444;
    mem[32'h2010] = 64'h5555_6666_7777_8888;
    mem[32'h2018] = 64'h0000_0000_0000_0401;
    mem[32'h2020] = {32'h0000_1000, 1'b0, 15'h0007, 16'h0002};
    mem[32'h2200] = mk_hdr(4'h2, 8'd1, 1'b0, 24'h100, 4'h0, 12'h202);
    mem[32'h2208] = 64'hdead_beef_0000_0001;
    mem[32'h2210] = 64'hcafe_f00d_0000_0002;
    mem[32'h2218] = 64'h0000_0000_8000_0010;
    mem[32'h2220] = {32'h0000_0200, 1'b1, 15'h0001, 16'h0005};
    mem[32'h2228] = {32'd16, 16'h0001, 16'haaaa};
    mem[32'h2238] = {32'd0, 16'h0002, 16'hbbbb};
    mem[32'h2300] = mk_hdr(4'h7, 8'd0, 1'b1, 24'h000, 4'h0, 12'h303);
    // T3: unknown version
    mem[32'h3000] = mk_hdr(4'h1, 8'd0, 1'b0, 24'h040, 4'h0, 12'h401);
    mem[32'h3040] = mk_hdr(4'h6, 8'd2, 1'b0, 24'h040, 4'h5, 12'h444);
    // T4: self-linked header
    mem[32'h4000] = mk_hdr(4'h2, 8'd0, 1'b0, 24'h000, 4'h0, 12'h505);
    // T5: over-long parameter chain
    mem[32'h5000] = mk_hdr(4'h3, 8'd1, 1'b1, 24'h000, 4'h1, 12'h606);
    mem[32'h5018] = 64'h0000_0000_0000_0101;
    mem[32'h5020] = {32'h0000_0040, 1'b1, 15'h0003, 16'h0009};
    for (int i = 0; i < 5; i++) begin
      a = 32'h5028 + 32'(16 * i);
      mem[a] = {(i == 4) ? 32'd0 : 32'd16, 16'(i), 16'(16'h7000 + i)};
    end

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, done, rd_req, fv, pv, lim} == 6'b0, "R1 reset state",
        256'({busy, done, rd_req, fv, pv, lim}), 256'(0));

    run_walk(32'h1000, 0, "R3 R4 format-0 chain");
    run_walk(32'h2000, 1, "R5 R6 R7 mixed list with stalls");
    run_walk(32'h3000, 0, "R8 unknown version");
    run_walk(32'h4000, 1, "R9 feature limit");
    chk(lim == 1'b1, "R9 limit error is sticky while idle", 256'(lim), 256'(1));
    run_walk(32'h5000, 0, "R10 parameter limit");
    run_walk(32'h1000, 1, "R9 restart clears limit error");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog expired", 256'(cyc), 256'(0));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule